// File: doc/BRIEF.md
# Power-Fail Chip-Enable Write-Protect Gate

This clocked block sits between an address decoder's active-low chip enable and the chip enable of a battery-backed memory. While the supply is healthy, the memory enable follows the decoder enable with no added cycle. When a synchronized power-fail flag rises, an access that is already driving the memory is allowed to finish. After that, the memory stays deselected for the rest of the outage.

When the supply returns, a recovery count of `REC_CYCLES` clock cycles must run out before accesses are passed again. If power drops during the count, the count starts again from zero. At the end of recovery the battery-low flag is captured. If it is set, the second access after recovery is swallowed, and the first and third accesses pass normally. Host software sees a weak battery through a read, complement-write and read-back sequence: the read-back does not match.

While an in-flight access is being completed during a failure, a cycle counter watches how long it lasts. If it runs too long for data to be safe, a sticky flag is raised.

Top module: `pf_ce_gate`

## Requirements
- R1: After reset, `mem_ce_n` is 1 and `long_hold_flag` is 0, and `mem_ce_n` stays 1 whatever `dec_ce_n` does until a full recovery period has completed.
- R2: In normal operation, `mem_ce_n` equals `dec_ce_n` combinationally, with no added cycle, except for an inhibited access (R7).
- R3: If `pwr_fail` is first sampled high while `mem_ce_n` is 0, `mem_ce_n` stays 0 for as long as `dec_ce_n` stays 0, and it goes to 1 in the same cycle that `dec_ce_n` goes to 1.
- R4: Once `mem_ce_n` is 1 during a failure, it stays 1 for as long as `pwr_fail` stays high, whatever `dec_ce_n` does.
- R5: If `pwr_fail` is first sampled low at clock edge E, `mem_ce_n` is held at 1 through edge E+`REC_CYCLES`-1 and follows `dec_ce_n` from edge E+`REC_CYCLES` on.
- R6: If `pwr_fail` is sampled high again before recovery completes, the recovery count restarts from zero at the next low sample.
- R7: If `batt_low` is 1 at the edge where recovery completes, the second access after recovery keeps `mem_ce_n` at 1 for its whole length. The first and third accesses pass. An access is counted at a 1-to-0 transition of `dec_ce_n`.
- R8: If `batt_low` is 0 at the edge where recovery completes, every access passes. A later change of `batt_low` has no effect until the next recovery.
- R9: Falling edges of `dec_ce_n` before recovery completes are not counted, so the inhibited access is the second one after recovery.
- R10: `long_hold_flag` rises if `dec_ce_n` is still 0 at `PULSE_LIMIT` or more clock edges after the edge that entered the completion phase. It then stays at 1 until reset, and it never rises otherwise.
- R11: If a failure is detected while the inhibited access is in progress, `mem_ce_n` stays 1 and no completion phase is entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_ce_n | input | 1 | Active-low chip enable from the address decoder |
| pwr_fail | input | 1 | Synchronized supply-out-of-tolerance flag, high during a failure |
| batt_low | input | 1 | Weak-battery flag, sampled when recovery completes |
| mem_ce_n | output | 1 | Active-low chip enable to the memory |
| long_hold_flag | output | 1 | Sticky flag: an access completed during a failure ran too long |

## Verification
The bench sweeps every point at which recovery can be cut short by a new failure. A timer that failed to clear would open the memory early. It also sweeps the length of the access being completed across the `PULSE_LIMIT` boundary. An off-by-one counter would set the flag one cycle early or one cycle late, and a gate that forced the enable high at detection would cut the write short.

The battery check is run with a weak and a good battery, with a late change of the battery flag, and with enable pulses during recovery. A design that counted those pulses, or that sampled the flag at the wrong time, would inhibit the wrong access. A failure that arrives during the swallowed access checks that the gate does not drop the enable into a memory that was never selected.

// File: rtl/pfg_pkg.sv
package pfg_pkg;

  typedef enum logic [1:0] {
    ST_BLOCKED = 2'd0,
    ST_RECOVER = 2'd1,
    ST_NORMAL  = 2'd2,
    ST_DRAIN   = 2'd3
  } gate_state_t;

  // A 1-to-0 step of the active-low enable between two samples.
  function automatic logic fn_fall(input logic prev_n, input logic cur_n);
    return prev_n & ~cur_n;
  endfunction

  // Access index saturating at 3 (0: none yet, 1: first seen, 2: second seen).
  function automatic logic [1:0] fn_sat_inc(input logic [1:0] idx);
    return (idx == 2'd3) ? idx : idx + 2'd1;
  endfunction

  // Second access in progress: either its falling edge is happening now,
  // or it was counted and the enable is still low.
  function automatic logic fn_second_live(input logic [1:0] idx,
                                          input logic prev_n,
                                          input logic cur_n);
    return ~cur_n & (((idx == 2'd1) & prev_n) | ((idx == 2'd2) & ~prev_n));
  endfunction

  // Enable value presented to memory for a given state.
  function automatic logic fn_gate(input gate_state_t st,
                                   input logic dec_n,
                                   input logic inhibit);
    case (st)
      ST_NORMAL: return dec_n | inhibit;
      ST_DRAIN:  return dec_n;
      default:   return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/pfg_rec_timer.sv
module pfg_rec_timer #(
  parameter int unsigned CYCLES = 250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int unsigned CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q;

  assign done = run & (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!run)   cnt_q <= '0;
    else if (!done)  cnt_q <= cnt_q + 1'b1;
  end

  // R6
  timer_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  // R6
  timer_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(run) |-> cnt_q == '0);

endmodule

// File: rtl/pfg_access_tracker.sv
module pfg_access_tracker
  import pfg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic dec_ce_n,
  input  logic active,
  input  logic arm,
  input  logic batt_low,
  output logic inhibit
);
  logic       ce_q;
  logic [1:0] idx_q;
  logic       weak_q;
  logic       fall_evt;

  assign fall_evt = fn_fall(ce_q, dec_ce_n);
  assign inhibit  = active & weak_q & fn_second_live(idx_q, ce_q, dec_ce_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_q   <= 1'b1;
      idx_q  <= 2'd0;
      weak_q <= 1'b0;
    end else begin
      ce_q <= dec_ce_n;
      if (arm) begin
        idx_q  <= 2'd0;
        weak_q <= batt_low;
      end else if (active && fall_evt) begin
        idx_q <= fn_sat_inc(idx_q);
      end
    end
  end

  // R7
  inhibit_weak_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit |-> weak_q && active);

  // R9
  idx_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(active) && !$past(arm) |-> idx_q >= $past(idx_q));

  // R8
  weak_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(arm) |-> $stable(weak_q));

endmodule

// File: rtl/pfg_pulse_watch.sv
module pfg_pulse_watch #(
  parameter int unsigned LIMIT = 75
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_drain,
  output logic flag
);
  localparam int unsigned PW = $clog2(LIMIT + 1);
  localparam logic [PW-1:0] TOP = PW'(LIMIT);

  logic [PW-1:0] cnt_q;
  logic          hit;

  assign hit = in_drain & (cnt_q == TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      flag  <= 1'b0;
    end else begin
      if (!in_drain)        cnt_q <= '0;
      else if (cnt_q != TOP) cnt_q <= cnt_q + 1'b1;
      flag <= flag | hit;
    end
  end

  // R10
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(flag) |-> flag);

  // R10
  flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(in_drain));

endmodule

// File: rtl/pf_ce_gate.sv
module pf_ce_gate
  import pfg_pkg::*;
#(
  parameter int unsigned REC_CYCLES  = 250000,
  parameter int unsigned PULSE_LIMIT = 75
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dec_ce_n,
  input  logic pwr_fail,
  input  logic batt_low,
  output logic mem_ce_n,
  output logic long_hold_flag
);
  gate_state_t st_q, st_d;
  logic in_recover, in_normal, in_drain;
  logic rec_done;
  logic inhibit;

  assign in_recover = (st_q == ST_RECOVER);
  assign in_normal  = (st_q == ST_NORMAL);
  assign in_drain   = (st_q == ST_DRAIN);

  pfg_rec_timer #(.CYCLES(REC_CYCLES)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (in_recover & ~pwr_fail),
    .done (rec_done)
  );

  pfg_access_tracker u_track (
    .clk     (clk),
    .rst_n   (rst_n),
    .dec_ce_n(dec_ce_n),
    .active  (in_normal),
    .arm     (rec_done),
    .batt_low(batt_low),
    .inhibit (inhibit)
  );

  pfg_pulse_watch #(.LIMIT(PULSE_LIMIT)) u_watch (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_drain(in_drain),
    .flag    (long_hold_flag)
  );

  assign mem_ce_n = fn_gate(st_q, dec_ce_n, inhibit);

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_BLOCKED: if (!pwr_fail) st_d = ST_RECOVER;
      ST_RECOVER: begin
        if (pwr_fail)      st_d = ST_BLOCKED;
        else if (rec_done) st_d = ST_NORMAL;
      end
      ST_NORMAL: if (pwr_fail) st_d = mem_ce_n ? ST_BLOCKED : ST_DRAIN;
      ST_DRAIN:  if (dec_ce_n) st_d = ST_BLOCKED;
      default:   st_d = ST_BLOCKED;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_BLOCKED;
    else        st_q <= st_d;
  end

  // R1
  closed_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_normal && !in_drain |-> mem_ce_n);

  // R3
  drain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_drain && !dec_ce_n |-> !mem_ce_n);

  // R4
  fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail && $past(pwr_fail) && $past(mem_ce_n) |-> mem_ce_n);

  // R5
  normal_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_normal && !$past(in_normal) |-> $past(rec_done));

  // R11
  no_drain_when_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_drain && !$past(in_drain) |-> !$past(mem_ce_n));

endmodule

// File: tb/pf_ce_gate_bench.sv
module pf_ce_gate_bench;
  localparam int unsigned R = 6;
  localparam int unsigned L = 4;
  localparam time CLK_P = 20ns;

  logic clk = 1'b0;
  logic rst_n, dec_ce_n, pwr_fail, batt_low;
  logic mem_ce_n, long_hold_flag;
  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  pf_ce_gate #(.REC_CYCLES(R), .PULSE_LIMIT(L)) u_pf_ce_gate (
    .clk(clk), .rst_n(rst_n), .dec_ce_n(dec_ce_n), .pwr_fail(pwr_fail),
    .batt_low(batt_low), .mem_ce_n(mem_ce_n), .long_hold_flag(long_hold_flag)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; pwr_fail = 1'b1; dec_ce_n = 1'b1; batt_low = 1'b0;
    step(); step();
    rst_n = 1'b1;
    step();
  endtask

  task automatic recover(input logic b);
    pwr_fail = 1'b0; batt_low = b; dec_ce_n = 1'b1;
    repeat (R + 1) step();
  endtask

  // One two-cycle access; pass=1 means the memory must see it.
  task automatic access(input string req, input logic pass);
    dec_ce_n = 1'b0; #1;
    chk(req, mem_ce_n, ~pass);
    step(); chk(req, mem_ce_n, ~pass);
    step(); chk(req, mem_ce_n, ~pass);
    dec_ce_n = 1'b1; #1;
    chk(req, mem_ce_n, 1'b1);
    step();
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1: reset state, blocked while failure persists
    chk("R1", mem_ce_n, 1'b1);
    chk("R1", long_hold_flag, 1'b0);
    for (int i = 0; i < 10; i++) begin
      dec_ce_n = i[0]; #1;
      chk("R1", mem_ce_n, 1'b1);
      step();
    end

    // R5: exact recovery length
    pwr_fail = 1'b0; dec_ce_n = 1'b0;
    for (int i = 1; i <= R; i++) begin
      step(); chk("R5", mem_ce_n, 1'b1);
    end
    step(); chk("R5", mem_ce_n, 1'b0);
    dec_ce_n = 1'b1; step();

    // R2: pattern sweep in normal operation
    for (int i = 0; i < 64; i++) begin
      dec_ce_n = ((i * 5) % 7) > 2; #1;
      chk("R2", mem_ce_n, dec_ce_n);
      step();
    end
    dec_ce_n = 1'b1; step();

    // R4: failure with enable idle
    pwr_fail = 1'b1; step();
    for (int i = 0; i < 8; i++) begin
      dec_ce_n = i[0]; #1;
      chk("R4", mem_ce_n, 1'b1);
      step();
    end
    dec_ce_n = 1'b1;

    // R6: cut recovery short at every point
    for (int cut = 1; cut < R; cut++) begin
      pwr_fail = 1'b0;
      repeat (cut) step();
      pwr_fail = 1'b1; step();
      chk("R6", mem_ce_n, 1'b1);
      pwr_fail = 1'b0; dec_ce_n = 1'b0;
      for (int i = 1; i <= R; i++) begin
        step(); chk("R6", mem_ce_n, 1'b1);
      end
      step(); chk("R6", mem_ce_n, 1'b0);
      dec_ce_n = 1'b1; step();
      pwr_fail = 1'b1; step();
    end

    // R7 / R8: battery check for both flag values
    for (int b = 0; b < 2; b++) begin
      recover(b[0]);
      access("R7", 1'b1);
      access(b ? "R7" : "R8", ~b[0]);
      access("R7", 1'b1);
      access("R7", 1'b1);
      pwr_fail = 1'b1; step();
    end
    // R8: late change of batt_low ignored
    recover(1'b0);
    batt_low = 1'b1;
    access("R8", 1'b1);
    access("R8", 1'b1);
    access("R8", 1'b1);
    pwr_fail = 1'b1; step();

    // R9: pulses during recovery are not counted
    pwr_fail = 1'b0; batt_low = 1'b1; dec_ce_n = 1'b1;
    step(); dec_ce_n = 1'b0; step(); dec_ce_n = 1'b1; step();
    dec_ce_n = 1'b0; step(); dec_ce_n = 1'b1;
    repeat (R - 3) step();
    access("R9", 1'b1);
    access("R9", 1'b0);
    access("R9", 1'b1);
    pwr_fail = 1'b1; step();

    // R11: failure during the swallowed access
    recover(1'b1);
    access("R11", 1'b1);
    dec_ce_n = 1'b0; #1;
    chk("R11", mem_ce_n, 1'b1);
    step();
    pwr_fail = 1'b1; step();
    chk("R11", mem_ce_n, 1'b1);
    step(); chk("R11", mem_ce_n, 1'b1);
    dec_ce_n = 1'b1; step();
    dec_ce_n = 1'b0; #1;
    chk("R11", mem_ce_n, 1'b1);
    dec_ce_n = 1'b1; step();
    chk("R11", long_hold_flag, 1'b0);

    // R3 / R10: completion length swept across the limit
    for (int k = 0; k <= L + 2; k++) begin
      do_reset();
      recover(1'b0);
      dec_ce_n = 1'b0; step();
      chk("R2", mem_ce_n, 1'b0);
      pwr_fail = 1'b1; step();
      chk("R3", mem_ce_n, 1'b0);
      for (int j = 1; j <= k; j++) begin
        step(); chk("R3", mem_ce_n, 1'b0);
      end
      dec_ce_n = 1'b1; #1;
      chk("R3", mem_ce_n, 1'b1);
      step();
      chk("R10", long_hold_flag, (k >= L));
      dec_ce_n = 1'b0; #1;
      chk("R4", mem_ce_n, 1'b1);
      step();
      recover(1'b0);
      chk("R10", long_hold_flag, (k >= L));
      pwr_fail = 1'b1; step();
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule